// File: doc/BRIEF.md
# Synchronous Serial Port (SPI Master/Slave)

This block is a byte-wide synchronous serial port that acts either as the clock-driving side (master) or the clock-following side (slave) of an SPI link. A 4-bit mode input selects the role and, for a master, the bit rate. A clock-polarity input sets the idle level of the serial clock. A write strobe on the buffer interface loads the shift register. In master mode the same write also starts a transfer. Every transfer is full duplex: one byte leaves on the data output while one byte arrives on the data input.

When the eighth bit has been clocked, the received byte moves into a receive buffer and a full flag rises. A buffer read strobe lowers that flag. Two error conditions raise sticky flags. One is a write that arrives while a transfer is still running. The other is a byte that completes while the buffer still holds an unread byte. Dropping the enable input returns all shift logic and flags to their idle state, so the mode and polarity can be changed safely before the port is enabled again.

Top module: `sync_serial_port`

## Requirements
- R1: While `en` is low, `sck_oe` and `sdo_oe` are 0, buffer writes are ignored, and `full_flag`, `wcol_flag` and `ovf_flag` are 0. Lowering `en` in the middle of a transfer aborts it and clears all three flags.
- R2: Mode decode: `mode` values 4'b0000 to 4'b0011 select master (`sck_oe`=1). Values 4'b0100 and 4'b0101 select slave (`sck_oe`=0). Every other value leaves the port inactive, with both output enables at 0.
- R3: The master's serial clock period is 4, 16 or 64 system clocks for `mode` 4'b0000, 4'b0001 and 4'b0010. For 4'b0011 the clock advances one half period per `tmr_tick` pulse.
- R4: Between transfers `sck_o` rests at the level of `cpol`. The first edge of each bit, called the leading edge, moves the clock away from that level.
- R5: The byte is sent most significant bit first on `sdo`. The next bit is presented at each trailing edge. Received bits enter at the least significant end, and eight clocked bits both send and receive one byte.
- R6: In master mode, `smp`=0 samples `sdi` at the leading edge (mid-bit) and `smp`=1 samples it at the trailing edge (end of bit).
- R7: After the eighth bit the received byte appears on `rd_data` and `full_flag` rises. A one-cycle `rd_stb` pulse lowers `full_flag` on the next clock.
- R8: A buffer write while a transfer is in progress sets `wcol_flag`. That write is discarded, and the byte in flight is sent unchanged.
- R9: If a byte completes while `full_flag` is still 1, `ovf_flag` is set and `rd_data` keeps the earlier byte.
- R10: In slave mode the port never drives `sck_o` active. It follows `sck_i` with the same edge rules as R4 and R5, sampling at the leading edge. In `mode` 4'b0101 the `ss_n` input has no effect.
- R11: In slave `mode` 4'b0100, a high `ss_n` turns off `sdo_oe` and resets the bit count. A partial byte is therefore discarded, and the next selected transfer receives a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low holds the logic in reset |
| mode | input | 4 | Role and bit-rate select |
| cpol | input | 1 | Serial clock idle level |
| smp | input | 1 | Master sample point: 0 leading edge, 1 trailing edge |
| tmr_tick | input | 1 | External bit-rate tick for mode 4'b0011 |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Buffer read strobe |
| rd_data | output | 8 | Last received byte |
| full_flag | output | 1 | Receive buffer holds an unread byte |
| wcol_flag | output | 1 | Write collision occurred |
| ovf_flag | output | 1 | Receive overflow occurred |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
The bench uses the default parameters: 8-bit data, a base half period of 2 clocks with a factor of 4 between rates, and a 2-stage input synchroniser. With these values even the slowest divider (64 clocks per bit, 512 per byte) finishes quickly, so all three divider rates and the tick-driven rate are each measured from the `sck_o` period. The short synchroniser lets a bench-driven slave clock of 16 system clocks per bit exercise slave transfers, select-line aborts and overflow within a few thousand cycles.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ROLE_OFF,
        ROLE_MASTER,
        ROLE_SLAVE_SEL,
        ROLE_SLAVE_FREE
    } role_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_ev_t;

    function automatic role_e decode_role(input logic [3:0] m);
        if (m[3:2] == 2'b00)
            return ROLE_MASTER;
        else if (m[3:1] == 3'b010)
            return m[0] ? ROLE_SLAVE_FREE : ROLE_SLAVE_SEL;
        else
            return ROLE_OFF;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int BASE_HALF = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       srst,
    input  logic [1:0] rate,
    input  logic       tmr_tick,
    input  logic       start,
    input  logic       last_bit,
    output edge_ev_t   ev,
    output logic       running,
    output logic       phase
);
    localparam int MAX_HALF = BASE_HALF << (2 * STEP_LOG2);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_len;
    logic             use_tick;
    logic             step;

    always_comb begin
        case (rate)
            2'd0:    half_len = CNT_W'(BASE_HALF);
            2'd1:    half_len = CNT_W'(BASE_HALF << STEP_LOG2);
            default: half_len = CNT_W'(MAX_HALF);
        endcase
    end

    assign use_tick = (rate == 2'd3);
    assign step     = running && (use_tick ? tmr_tick : (cnt == half_len - 1'b1));
    assign ev.lead  = step && !phase;
    assign ev.trail = step && phase;

    always_ff @(posedge clk) begin
        if (srst) begin
            running <= 1'b0;
            phase   <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            phase   <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt <= (step || use_tick) ? '0 : cnt + 1'b1;
            if (step)
                phase <= ~phase;
            if (step && phase && last_bit)
                running <= 1'b0;
        end
    end

endmodule

// File: rtl/ssp_slave_front.sv
module ssp_slave_front
    import ssp_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic     clk,
    input  logic     srst,
    input  logic     cpol,
    input  logic     sck_i,
    input  logic     sdi,
    input  logic     ss_n,
    output edge_ev_t ev,
    output logic     sdi_s,
    output logic     ss_s
);
    logic [SYNC_DEPTH-1:0] sck_p;
    logic [SYNC_DEPTH-1:0] sdi_p;
    logic [SYNC_DEPTH-1:0] ss_p;
    logic                  sck_prev;
    logic                  sck_now;

    always_ff @(posedge clk) begin
        if (srst) begin
            sck_p    <= {SYNC_DEPTH{cpol}};
            sdi_p    <= '0;
            ss_p     <= '1;
            sck_prev <= cpol;
        end else begin
            sck_p    <= {sck_p[SYNC_DEPTH-2:0], sck_i};
            sdi_p    <= {sdi_p[SYNC_DEPTH-2:0], sdi};
            ss_p     <= {ss_p[SYNC_DEPTH-2:0], ss_n};
            sck_prev <= sck_p[SYNC_DEPTH-1];
        end
    end

    assign sck_now  = sck_p[SYNC_DEPTH-1];
    assign ev.lead  = (sck_prev == cpol) && (sck_now != cpol);
    assign ev.trail = (sck_prev != cpol) && (sck_now == cpol);
    assign sdi_s    = sdi_p[SYNC_DEPTH-1];
    assign ss_s     = ss_p[SYNC_DEPTH-1];

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  edge_ev_t          ev,
    input  logic              sdi_x,
    input  logic              smp_end,
    input  logic              abort,
    input  logic              busy,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic              sr_msb,
    output logic              active,
    output logic              last_bit,
    output logic              done,
    output logic [DATA_W-1:0] buffer,
    output logic              full,
    output logic              wcol,
    output logic              ovf
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] sr;
    logic [DATA_W-1:0] rx_next;
    logic [CW-1:0]     bitcnt;
    logic              half;
    logic              samp;
    logic              accept;

    assign last_bit = (bitcnt == CW'(DATA_W - 1));
    assign done     = ev.trail && last_bit && !abort && !srst;
    assign rx_next  = {sr[DATA_W-2:0], smp_end ? sdi_x : samp};
    assign accept   = done && (!full || rd_stb);
    assign active   = (bitcnt != '0) || half;
    assign sr_msb   = sr[DATA_W-1];

    always_ff @(posedge clk) begin
        if (srst) begin
            sr     <= '0;
            bitcnt <= '0;
            half   <= 1'b0;
            samp   <= 1'b0;
            full   <= 1'b0;
            wcol   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (wr_stb) begin
                if (busy) wcol <= 1'b1;
                else      sr   <= wr_data;
            end
            if (abort) begin
                bitcnt <= '0;
                half   <= 1'b0;
            end else begin
                if (ev.lead) begin
                    samp <= sdi_x;
                    half <= 1'b1;
                end
                if (ev.trail) begin
                    sr     <= rx_next;
                    half   <= 1'b0;
                    bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
                end
            end
            if (done) begin
                if (accept) full <= 1'b1;
                else        ovf  <= 1'b1;
            end else if (rd_stb) begin
                full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            buffer <= '0;
        else if (accept)
            buffer <= rx_next;
    end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BASE_HALF  = 2,
    parameter int STEP_LOG2  = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [3:0]        mode,
    input  logic              cpol,
    input  logic              smp,
    input  logic              tmr_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_flag,
    output logic              wcol_flag,
    output logic              ovf_flag,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              ss_n
);
    role_e    role;
    logic     is_master;
    logic     srst;
    logic     start;
    logic     busy;
    logic     abort;
    logic     m_running;
    logic     m_phase;
    logic     last_bit;
    logic     done_ev;
    logic     sh_active;
    logic     s_sdi;
    logic     s_ss;
    edge_ev_t m_ev;
    edge_ev_t s_ev;
    edge_ev_t ev;

    assign role      = decode_role(mode);
    assign is_master = (role == ROLE_MASTER);
    assign srst      = rst || !en || (role == ROLE_OFF);
    assign busy      = m_running || sh_active;
    assign start     = wr_stb && !busy && is_master;
    assign abort     = (role == ROLE_SLAVE_SEL) && s_ss;
    assign ev        = is_master ? m_ev : s_ev;

    ssp_clkgen #(
        .BASE_HALF (BASE_HALF),
        .STEP_LOG2 (STEP_LOG2)
    ) u_clkgen (
        .clk      (clk),
        .srst     (srst || !is_master),
        .rate     (mode[1:0]),
        .tmr_tick (tmr_tick),
        .start    (start),
        .last_bit (last_bit),
        .ev       (m_ev),
        .running  (m_running),
        .phase    (m_phase)
    );

    ssp_slave_front #(
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_front (
        .clk   (clk),
        .srst  (srst),
        .cpol  (cpol),
        .sck_i (sck_i),
        .sdi   (sdi),
        .ss_n  (ss_n),
        .ev    (s_ev),
        .sdi_s (s_sdi),
        .ss_s  (s_ss)
    );

    ssp_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst),
        .ev       (ev),
        .sdi_x    (is_master ? sdi : s_sdi),
        .smp_end  (is_master && smp),
        .abort    (abort),
        .busy     (busy),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .sr_msb   (sdo),
        .active   (sh_active),
        .last_bit (last_bit),
        .done     (done_ev),
        .buffer   (rd_data),
        .full     (full_flag),
        .wcol     (wcol_flag),
        .ovf      (ovf_flag)
    );

    assign sck_o  = cpol ^ (is_master && m_phase);
    assign sck_oe = en && is_master;
    assign sdo_oe = en && (role != ROLE_OFF) && !abort;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [3:0]        mode,
    input logic              cpol,
    input logic              sck_o,
    input logic              sck_oe,
    input logic              busy,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              full_flag,
    input logic              wcol_flag,
    input logic              ovf_flag,
    input logic              done_ev,
    input logic              abort,
    input logic              sh_active
);
    assert_flags_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |=> (!full_flag && !wcol_flag && !ovf_flag));

    assert_master_mode_R2: assert property (@(posedge clk) disable iff (rst)
        sck_oe |-> (mode[3:2] == 2'b00));

    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !busy) |-> (sck_o == cpol));

    assert_full_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (en && rd_stb && !done_ev) |=> !full_flag);

    assert_wcol_set_R8: assert property (@(posedge clk) disable iff (rst)
        (en && busy && wr_stb) |=> wcol_flag);

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $stable(rd_data));

    assert_abort_count_R11: assert property (@(posedge clk) disable iff (rst)
        abort |=> !sh_active);
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode      (mode),
    .cpol      (cpol),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .busy      (busy),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .full_flag (full_flag),
    .wcol_flag (wcol_flag),
    .ovf_flag  (ovf_flag),
    .done_ev   (done_ev),
    .abort     (abort),
    .sh_active (sh_active)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
    localparam int H = 8;

    logic       clk = 0;
    logic       rst = 1;
    logic       en = 0;
    logic [3:0] mode = 4'b0000;
    logic       cpol = 0;
    logic       smp = 0;
    logic       tmr_tick = 0;
    logic       wr_stb = 0;
    logic [7:0] wr_data = 0;
    logic       rd_stb = 0;
    logic [7:0] rd_data;
    logic       full_flag, wcol_flag, ovf_flag;
    logic       sck_i = 0;
    logic       sck_o, sck_oe;
    logic       sdi = 0;
    logic       sdo, sdo_oe;
    logic       ss_n = 1;

    sync_serial_port u_sync_serial_port (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .cpol(cpol), .smp(smp),
        .tmr_tick(tmr_tick), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_data(rd_data), .full_flag(full_flag), .wcol_flag(wcol_flag),
        .ovf_flag(ovf_flag), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
    );

    always #10 clk = ~clk;

    int   errors = 0;
    int   checks = 0;
    bit   finished = 0;
    int   cyc = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // timer tick: one pulse every 5 clocks while enabled
    bit tick_on = 0;
    int tick_cnt = 0;
    always @(negedge clk) begin
        tmr_tick = 0;
        if (tick_on) begin
            tick_cnt++;
            if (tick_cnt == 5) begin tick_cnt = 0; tmr_tick = 1; end
        end
    end

    // bench slave model for master transfers, plus clock period meter
    logic [7:0] m_sb, m_alt, mosi_cap;
    bit   m_use_alt = 0;
    int   m_bits = 0;
    logic sck_prev = 0;
    int   last_rise = -1;
    int   last_period = 0;
    always @(negedge clk) begin
        if (sck_oe && sck_o != sck_prev) begin
            if (sck_o != cpol) begin
                mosi_cap = {mosi_cap[6:0], sdo};
                if (m_use_alt && m_bits < 8) sdi = m_alt[7 - m_bits];
            end else begin
                m_bits++;
                if (m_bits < 8) sdi = m_sb[7 - m_bits];
            end
        end
        if (sck_oe && sck_o && !sck_prev) begin
            if (last_rise >= 0) last_period = cyc - last_rise;
            last_rise = cyc;
        end
        sck_prev = sck_o;
    end

    // scoreboard monitor: compare each newly filled buffer with the queue
    logic full_prev = 0;
    always @(negedge clk) begin
        if (full_flag && !full_prev) begin
            if (exp_q.size() == 0)
                check(0, "R7 unexpected byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R5/R7 received byte", rd_data, e);
            end
        end
        full_prev = full_flag;
    end

    task automatic wr_pulse(input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_stb = 1;
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic rd_pulse(input string req);
        @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0;
        check(full_flag == 0, req, full_flag, 0);
    endtask

    task automatic reconfig(input logic [3:0] m, input logic p, input logic s);
        @(negedge clk); en = 0;
        @(negedge clk); mode = m; cpol = p; smp = s; sck_i = p; sck_prev = p;
        @(negedge clk); en = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic master_start(input logic [7:0] tx, input logic [7:0] sb,
                                input logic [7:0] alt, input bit use_alt);
        m_sb = sb; m_alt = alt; m_use_alt = use_alt; m_bits = 0; mosi_cap = 0;
        sdi = sb[7];
        wr_pulse(tx);
    endtask

    task automatic master_wait();
        for (int g = 0; g < 4000 && m_bits < 8; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic slave_bits(input logic [7:0] mb, input int nb, output logic [7:0] miso);
        miso = 0;
        for (int i = 0; i < nb; i++) begin
            sdi = mb[7 - i];
            repeat (H) @(negedge clk);
            sck_i = ~cpol;
            miso = {miso[6:0], sdo};
            repeat (H) @(negedge clk);
            sck_i = cpol;
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] miso;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset / disabled state
        check(!sck_oe && !sdo_oe, "R1 output enables while disabled", {sck_oe, sdo_oe}, 0);
        check(!full_flag && !wcol_flag && !ovf_flag, "R1 flags while disabled",
              {full_flag, wcol_flag, ovf_flag}, 0);
        wr_pulse(8'hA5);
        repeat (40) @(negedge clk);
        check(!full_flag && !wcol_flag && sck_o == cpol, "R1 write ignored while disabled",
              {full_flag, wcol_flag, sck_o}, 0);

        // R2/R4/R3: master, divide by 4
        reconfig(4'b0000, 0, 0);
        check(sck_oe == 1 && sdo_oe == 1, "R2 master enables", {sck_oe, sdo_oe}, 3);
        check(sck_o == 0, "R4 idle level cpol=0", sck_o, 0);
        exp_q.push_back(8'h3C);
        master_start(8'hA5, 8'h3C, 0, 0);
        master_wait();
        check(mosi_cap == 8'hA5, "R5 sent byte msb first", mosi_cap, 8'hA5);
        check(last_period == 4, "R3 period mode0000", last_period, 4);
        rd_pulse("R7 read clears full");

        reconfig(4'b0001, 0, 0);
        exp_q.push_back(8'h96);
        master_start(8'h69, 8'h96, 0, 0);
        master_wait();
        check(last_period == 16, "R3 period mode0001", last_period, 16);
        rd_pulse("R7 read clears full");

        reconfig(4'b0010, 0, 0);
        exp_q.push_back(8'h5A);
        master_start(8'h0F, 8'h5A, 0, 0);
        master_wait();
        check(last_period == 64, "R3 period mode0010", last_period, 64);
        check(mosi_cap == 8'h0F, "R5 sent byte", mosi_cap, 8'h0F);
        rd_pulse("R7 read clears full");

        reconfig(4'b0011, 0, 0);
        tick_on = 1;
        exp_q.push_back(8'hE1);
        master_start(8'h1E, 8'hE1, 0, 0);
        master_wait();
        tick_on = 0;
        check(last_period == 10, "R3 tick-driven period", last_period, 10);
        rd_pulse("R7 read clears full");

        // R4: inverted polarity
        reconfig(4'b0000, 1, 0);
        check(sck_o == 1, "R4 idle level cpol=1", sck_o, 1);
        exp_q.push_back(8'h81);
        master_start(8'hC3, 8'h81, 0, 0);
        master_wait();
        check(mosi_cap == 8'hC3 && sck_o == 1, "R4 cpol=1 transfer and idle", mosi_cap, 8'hC3);
        rd_pulse("R7 read clears full");

        // R6: sample point
        reconfig(4'b0000, 0, 0);
        exp_q.push_back(8'hB2);
        master_start(8'h44, 8'hB2, 8'h4D, 1);
        master_wait();
        rd_pulse("R6 mid-bit sample read");
        reconfig(4'b0000, 0, 1);
        exp_q.push_back(8'h4D);
        master_start(8'h44, 8'hB2, 8'h4D, 1);
        master_wait();
        rd_pulse("R6 end-of-bit sample read");

        // R8: write collision
        reconfig(4'b0000, 0, 0);
        exp_q.push_back(8'h22);
        master_start(8'h11, 8'h22, 0, 0);
        repeat (8) @(negedge clk);
        wr_pulse(8'hFF);
        check(wcol_flag == 1, "R8 collision flag", wcol_flag, 1);
        master_wait();
        check(mosi_cap == 8'h11, "R8 byte in flight unchanged", mosi_cap, 8'h11);
        rd_pulse("R7 read clears full");

        // R9: overflow
        reconfig(4'b0000, 0, 0);
        exp_q.push_back(8'h44);
        master_start(8'h01, 8'h44, 0, 0);
        master_wait();
        master_start(8'h02, 8'h55, 0, 0);
        master_wait();
        check(ovf_flag == 1, "R9 overflow flag", ovf_flag, 1);
        check(rd_data == 8'h44, "R9 buffer keeps old byte", rd_data, 8'h44);
        @(negedge clk); en = 0;
        @(negedge clk);
        check(!full_flag && !ovf_flag && !wcol_flag, "R1 flags cleared by disable",
              {full_flag, wcol_flag, ovf_flag}, 0);

        // R1: disable mid-transfer, then recover
        reconfig(4'b0000, 0, 0);
        master_start(8'h77, 8'h88, 0, 0);
        repeat (12) @(negedge clk);
        en = 0;
        @(negedge clk);
        check(!sck_oe && !sdo_oe, "R1 disable mid-transfer", {sck_oe, sdo_oe}, 0);
        reconfig(4'b0000, 0, 0);
        exp_q.push_back(8'h99);
        master_start(8'h66, 8'h99, 0, 0);
        master_wait();
        check(mosi_cap == 8'h66, "R1 transfer after re-enable", mosi_cap, 8'h66);
        rd_pulse("R7 read clears full");

        // R2: invalid mode
        reconfig(4'b0110, 0, 0);
        check(!sck_oe && !sdo_oe, "R2 invalid mode inactive", {sck_oe, sdo_oe}, 0);

        // R10: slave, select ignored
        ss_n = 1;
        reconfig(4'b0101, 0, 0);
        check(sck_oe == 0 && sdo_oe == 1, "R10 slave enables", {sck_oe, sdo_oe}, 1);
        wr_pulse(8'h3A);
        exp_q.push_back(8'hC6);
        slave_bits(8'hC6, 8, miso);
        check(miso == 8'h3A, "R10 slave sent byte", miso, 8'h3A);
        rd_pulse("R7 read clears full");

        // R11: slave with select, aborted partial byte
        ss_n = 0;
        reconfig(4'b0100, 1, 0);
        check(sdo_oe == 1, "R11 selected drives sdo", sdo_oe, 1);
        wr_pulse(8'h99);
        slave_bits(8'hF0, 4, miso);
        ss_n = 1;
        repeat (6) @(negedge clk);
        check(sdo_oe == 0, "R11 deselect tri-states sdo", sdo_oe, 0);
        check(full_flag == 0, "R11 partial byte discarded", full_flag, 0);
        ss_n = 0;
        repeat (6) @(negedge clk);
        wr_pulse(8'h5C);
        exp_q.push_back(8'h2B);
        slave_bits(8'h2B, 8, miso);
        check(miso == 8'h5C, "R11 fresh byte after reselect", miso, 8'h5C);
        rd_pulse("R7 read clears full");

        check(exp_q.size() == 0, "R7 all expected bytes seen", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule